// File: doc/BRIEF.md
# 100M Receive Stream Framer

This block sits on the receive side of a 100 Mb/s nibble interface, downstream of the 4B/5B decoder. Each clock it takes one decoded symbol: a 3-bit class code and the 4-bit nibble that goes with it. It finds stream boundaries in that flow and produces carrier sense, receive-data-valid, receive-error and a 4-bit receive nibble for the MAC. A stream opens on a J symbol followed at once by a K symbol. The J/K pair leaves the block as two preamble nibbles of value 0101, so data-valid lines up with the start of the stream. The stream closes on a T symbol followed at once by an R symbol. A stream that runs into idle without that pair is cut short and flagged. Any symbol that is not legal inside a stream comes out as a fixed error nibble with the error flag raised.

A small transmit-side helper registers the MAC's 5-bit code group. When the MAC requests a transmit error, it puts the 5-bit halt code in its place.

The receive outputs trail the input by two clocks. One register holds the previous symbol so that each symbol can be judged together with the one after it. A second register holds the outputs.

Top module: `nib_rx_framer`

## Requirements
- R1: Symbol class encoding on `sym_cls_i`: 0 data, 1 J, 2 K, 3 T, 4 R, 5 idle, 6 and 7 invalid. A J followed directly by a K starts a stream. The output slots of the J and of the K each show crs_o=1, rx_dv_o=1, rx_er_o=0 and rxd_o=4'b0101.
- R2: Receive outputs describe the symbol presented two rising edges earlier. Inside a stream, a data symbol gives crs_o=1, rx_dv_o=1, rx_er_o=0 and rxd_o equal to its nibble, in arrival order.
- R3: Inside a stream, a T followed directly by an R ends the stream. The T's slot and the R's slot both show crs_o=0, rx_dv_o=0, rx_er_o=0 and rxd_o=0.
- R4: An idle symbol inside a stream ends it early. Its slot shows crs_o=0, rx_dv_o=0, rx_er_o=1 and rxd_o=0, and rx_er_o is high for exactly that one clock. The block then searches for J/K again, starting with the very next symbol.
- R5: Inside a stream, an invalid symbol (class 6 or 7), a J, a K, an R, or a T not followed by R gives crs_o=1, rx_dv_o=1, rx_er_o=1 and rxd_o=4'b1110. The stream continues.
- R6: Outside a stream, every symbol other than the J of a J-then-K pair is ignored. All four receive outputs stay 0, including for invalid symbols, a lone J and a lone K.
- R7: rx_dv_o equals crs_o in every cycle.
- R8: tx_code_o is registered, one clock after the inputs. It is 5'b00100 when tx_er_i was high, and tx_code_i otherwise.
- R9: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_cls_i | input | 3 | Class of the current received symbol |
| sym_dat_i | input | 4 | Decoded nibble of the current received symbol |
| tx_er_i | input | 1 | MAC transmit-error request |
| tx_code_i | input | 5 | MAC transmit code group |
| crs_o | output | 1 | Carrier sense |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| rxd_o | output | 4 | Receive nibble |
| tx_code_o | output | 5 | Code group sent toward the line |

## Verification
The bench builds the block with its default widths: a 4-bit nibble, a 5-bit code group, preamble 0101, error nibble 1110 and halt code 00100. At these widths, every class code including the unassigned value 7 can be driven directly. The stimulus covers repeated J before K, a stream cut by idle followed at once by a new J/K, a T not followed by R, and noise between streams. The halt substitution is checked on every cycle alongside the receive side.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic [2:0] {
    CLS_DATA = 3'd0,
    CLS_J    = 3'd1,
    CLS_K    = 3'd2,
    CLS_T    = 3'd3,
    CLS_R    = 3'd4,
    CLS_IDLE = 3'd5,
    CLS_BAD  = 3'd6
  } sym_cls_e;

  typedef enum logic [1:0] {
    ST_SRCH = 2'd0,
    ST_PRE  = 2'd1,
    ST_BODY = 2'd2
  } frm_st_e;
endpackage

// File: rtl/sym_stage.sv
module sym_stage
  import framer_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sym_cls_e         cls_i,
  input  logic [NIB_W-1:0] dat_i,
  output sym_cls_e         cls_o,
  output logic [NIB_W-1:0] dat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_o <= CLS_IDLE;
      dat_o <= '0;
    end else begin
      cls_o <= cls_i;
      dat_o <= dat_i;
    end
  end
endmodule

// File: rtl/stream_fsm.sv
module stream_fsm
  import framer_pkg::*;
#(
  parameter int               NIB_W   = 4,
  parameter logic [NIB_W-1:0] PRE_NIB = 4'b0101,
  parameter logic [NIB_W-1:0] ERR_NIB = 4'b1110
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sym_cls_e         cur_cls_i,
  input  sym_cls_e         prv_cls_i,
  input  logic [NIB_W-1:0] prv_dat_i,
  output logic             crs_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic [NIB_W-1:0] rxd_o
);
  frm_st_e          st_q, st_d;
  logic             crs_d, dv_d, er_d;
  logic [NIB_W-1:0] rxd_d;
  logic             jk_seen;

  assign jk_seen = (prv_cls_i == CLS_J) && (cur_cls_i == CLS_K);

  always_comb begin
    st_d  = st_q;
    crs_d = 1'b0;
    dv_d  = 1'b0;
    er_d  = 1'b0;
    rxd_d = '0;
    unique case (st_q)
      ST_SRCH: if (jk_seen) begin
        {crs_d, dv_d, rxd_d} = {1'b1, 1'b1, PRE_NIB};
        st_d = ST_PRE;
      end
      ST_PRE: begin
        {crs_d, dv_d, rxd_d} = {1'b1, 1'b1, PRE_NIB};
        st_d = ST_BODY;
      end
      ST_BODY: begin
        if (prv_cls_i == CLS_T && cur_cls_i == CLS_R) begin
          st_d = ST_SRCH;
        end else if (prv_cls_i == CLS_IDLE) begin
          er_d = 1'b1;  // stream cut short
          st_d = ST_SRCH;
        end else if (prv_cls_i == CLS_DATA) begin
          {crs_d, dv_d, rxd_d} = {1'b1, 1'b1, prv_dat_i};
        end else begin
          {crs_d, dv_d, er_d, rxd_d} = {1'b1, 1'b1, 1'b1, ERR_NIB};
        end
      end
      default: st_d = ST_SRCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SRCH;
      crs_o   <= 1'b0;
      rx_dv_o <= 1'b0;
      rx_er_o <= 1'b0;
      rxd_o   <= '0;
    end else begin
      st_q    <= st_d;
      crs_o   <= crs_d;
      rx_dv_o <= dv_d;
      rx_er_o <= er_d;
      rxd_o   <= rxd_d;
    end
  end

  a_r1_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SRCH && prv_cls_i == CLS_J && cur_cls_i == CLS_K)
      |=> (crs_o && rx_dv_o && !rx_er_o && rxd_o == PRE_NIB));

  a_r3_tr_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BODY && prv_cls_i == CLS_T && cur_cls_i == CLS_R)
      |=> (!crs_o && !rx_er_o));

  a_r4_single_er: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_er_o && !crs_o) |=> !rx_er_o);

  a_r5_err_nib: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_er_o && crs_o) |-> (rxd_o == ERR_NIB));

  a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SRCH && !(prv_cls_i == CLS_J && cur_cls_i == CLS_K))
      |=> (!crs_o && !rx_dv_o && !rx_er_o));

  a_r7_dv_crs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dv_o == crs_o);
endmodule

// File: rtl/tx_halt_map.sv
module tx_halt_map #(
  parameter int               SYM_W     = 5,
  parameter logic [SYM_W-1:0] HALT_CODE = 5'b00100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_er_i,
  input  logic [SYM_W-1:0] tx_code_i,
  output logic [SYM_W-1:0] tx_code_o
);
  logic past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_code_o <= '0;
      past_ok_q <= 1'b0;
    end else begin
      tx_code_o <= tx_er_i ? HALT_CODE : tx_code_i;
      past_ok_q <= 1'b1;
    end
  end

  a_r8_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(tx_er_i)) |-> (tx_code_o == HALT_CODE));

  a_r8_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(tx_er_i)) |-> (tx_code_o == $past(tx_code_i)));
endmodule

// File: rtl/nib_rx_framer.sv
module nib_rx_framer
  import framer_pkg::*;
#(
  parameter int               NIB_W     = 4,
  parameter int               SYM_W     = 5,
  parameter logic [NIB_W-1:0] PRE_NIB   = 4'b0101,
  parameter logic [NIB_W-1:0] ERR_NIB   = 4'b1110,
  parameter logic [SYM_W-1:0] HALT_CODE = 5'b00100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       sym_cls_i,
  input  logic [NIB_W-1:0] sym_dat_i,
  input  logic             tx_er_i,
  input  logic [SYM_W-1:0] tx_code_i,
  output logic             crs_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic [NIB_W-1:0] rxd_o,
  output logic [SYM_W-1:0] tx_code_o
);
  sym_cls_e         cur_cls, prv_cls;
  logic [NIB_W-1:0] prv_dat;

  assign cur_cls = sym_cls_e'(sym_cls_i);

  sym_stage #(.NIB_W(NIB_W)) u_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cls_i (cur_cls),
    .dat_i (sym_dat_i),
    .cls_o (prv_cls),
    .dat_o (prv_dat)
  );

  stream_fsm #(.NIB_W(NIB_W), .PRE_NIB(PRE_NIB), .ERR_NIB(ERR_NIB)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cur_cls_i(cur_cls),
    .prv_cls_i(prv_cls),
    .prv_dat_i(prv_dat),
    .crs_o    (crs_o),
    .rx_dv_o  (rx_dv_o),
    .rx_er_o  (rx_er_o),
    .rxd_o    (rxd_o)
  );

  tx_halt_map #(.SYM_W(SYM_W), .HALT_CODE(HALT_CODE)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_er_i  (tx_er_i),
    .tx_code_i(tx_code_i),
    .tx_code_o(tx_code_o)
  );
endmodule

// File: tb/nib_rx_framer_tb.sv
`timescale 1ns/1ps
module nib_rx_framer_tb_top;
  localparam int D = 0, J = 1, K = 2, T = 3, R = 4, I = 5, B = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cls = 3'd5;
  logic [3:0] dat = '0;
  logic       te = 1'b0;
  logic [4:0] tc = '0;
  logic       crs, dv, er;
  logic [3:0] rxd;
  logic [4:0] txo;

  int total = 0, bad = 0, stepn = 0;
  // reference model state
  int m_st = 0, m_prev = I, m_pdat = 0;
  int e_crs = 0, e_dv = 0, e_er = 0, e_rxd = 0, e_tx = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nib_rx_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_cls_i(cls), .sym_dat_i(dat),
    .tx_er_i(te), .tx_code_i(tc), .crs_o(crs), .rx_dv_o(dv),
    .rx_er_o(er), .rxd_o(rxd), .tx_code_o(txo)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (step %0d)", tag, what, act, exp, stepn);
    end
  endtask

  task automatic model(input int c, input int d, input int t_er, input int t_c);
    e_crs = 0; e_dv = 0; e_er = 0; e_rxd = 0;
    if (m_st == 0) begin
      if (m_prev == J && c == K) begin e_crs = 1; e_rxd = 5; m_st = 1; end
    end else if (m_st == 1) begin
      e_crs = 1; e_rxd = 5; m_st = 2;
    end else begin
      if (m_prev == T && c == R) m_st = 0;
      else if (m_prev == I) begin e_er = 1; m_st = 0; end
      else if (m_prev == D) begin e_crs = 1; e_rxd = m_pdat; end
      else begin e_crs = 1; e_er = 1; e_rxd = 14; end
    end
    e_dv = e_crs;
    m_prev = c; m_pdat = d;
    e_tx = t_er ? 4 : t_c;
  endtask

  task automatic step(input int c, input int d, input string tag);
    cls = c[2:0]; dat = d[3:0];
    te = (stepn % 5 == 3); tc = stepn[4:0];
    @(posedge clk);
    model(c, d, int'(te), int'(tc));
    @(negedge clk);
    chk(tag, crs, e_crs, "crs");
    chk("R7", dv, crs, "dv_vs_crs");
    chk(tag, dv, e_dv, "dv");
    chk(tag, er, e_er, "er");
    chk(tag, rxd, e_rxd, "rxd");
    chk("R8", txo, e_tx, "tx_code");
    stepn++;
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    te = 1'b1; tc = 5'd31; cls = 3'd1;
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9", crs, 0, "crs"); chk("R9", dv, 0, "dv"); chk("R9", er, 0, "er");
    chk("R9", rxd, 0, "rxd"); chk("R9", txo, 0, "tx_code");
    cls = 3'd5; te = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R6: noise between streams
    step(B, 3, "R6"); step(K, 0, "R6"); step(J, 0, "R6"); step(D, 9, "R6");
    step(7, 0, "R6"); step(T, 0, "R6"); step(R, 0, "R6"); step(I, 0, "R6");
    // R1/R2/R3: J J K then data then T R
    step(J, 0, "R1"); step(J, 0, "R1"); step(K, 0, "R1");
    for (int i = 0; i < 8; i++) step(D, (i * 7 + 3) % 16, "R2");
    step(T, 0, "R3"); step(R, 0, "R3"); step(I, 0, "R3"); step(I, 0, "R6");
    // R5: illegal symbols inside a stream
    step(J, 0, "R1"); step(K, 0, "R1"); step(D, 10, "R2");
    step(B, 0, "R5"); step(D, 15, "R5"); step(7, 2, "R5"); step(K, 0, "R5");
    step(T, 0, "R5"); step(D, 1, "R5"); step(R, 0, "R5"); step(J, 0, "R5");
    step(D, 6, "R2"); step(T, 0, "R3"); step(R, 0, "R3"); step(I, 0, "R3");
    // R4: early end on idle, then immediate new stream
    step(J, 0, "R1"); step(K, 0, "R1"); step(D, 4, "R2"); step(D, 12, "R2");
    step(I, 0, "R4"); step(J, 0, "R4"); step(K, 0, "R4"); step(D, 8, "R4");
    step(I, 0, "R4"); step(I, 0, "R4"); step(I, 0, "R4"); step(B, 0, "R6");
    step(I, 0, "R6"); step(I, 0, "R6");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule